// File: doc/BRIEF.md
# Cache Directory Freeze Controller

This block sits beside a direct-mapped external cache and decides, for every processor memory cycle, which of the cache's storage arrays may be written. It supports write-back and write-through operation. A freeze control stops new lines from being allocated, so a long block move cannot push useful lines out of the cache. While frozen, write hits still update the cached data and, in write-back mode, the dirty bit. Only allocation on a read miss is suppressed.

The block holds a small tag, valid and dirty array so that the hit result, the victim state and the effect of every enable can be observed. A freeze request that arrives while the cache is being initialised is held back. It takes effect once initialisation is over.

The address is split in two. The low `IDX_W` bits of `cyc_addr` select a line. The remaining upper bits form the tag. A cycle hits when the selected line is valid and its stored tag equals the upper address bits.

Top module: `cdir_freeze_ctrl`

## Requirements
- R1: An active read miss while not frozen raises `tag_we`, `data_we` and `fill_req` in the same cycle. It also raises `dirty_we` with `dirty_wdata` = 0. A later lookup of that address hits with `line_dirty` = 0.
- R2: An active read miss while `freeze_active` = 1 raises none of `tag_we`, `data_we`, `fill_req` or `dirty_we`. Any number of such misses leave every previously cached address still hitting.
- R3: An active write hit in write-back mode (`wb_mode` = 1) raises `data_we`, and raises `dirty_we` with `dirty_wdata` = 1. This holds frozen or not. The line then reads `line_dirty` = 1.
- R4: An active write hit in write-through mode (`wb_mode` = 0) raises `data_we` but never `dirty_we`. The line's dirty bit keeps its value.
- R5: An active write miss raises no enable and no fill, frozen or not, and the array is left unchanged.
- R6: An active read hit raises no enable and no fill, frozen or not.
- R7: While `init_busy` = 0, `freeze_active` takes the value that `freeze_req` had at the previous clock edge.
- R8: While `init_busy` = 1, `freeze_active` holds its value. The last `freeze_req` seen takes effect at the first edge where `init_busy` is sampled low.
- R9: While `init_busy` = 1, no enable or fill is raised and every line is invalidated and cleaned. After that, lookups miss.
- R10: `evict_wb` is 1 exactly when an allocating read miss (R1) replaces a line that is valid and dirty. It is never 1 on a frozen miss.
- R11: After reset, `freeze_active` = 0 and every line is invalid. The block's internal reset is released two clock edges after `rst_n` rises.
- R12: With `cyc_valid` = 0, no enable and no fill is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | A processor memory cycle is present |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_addr | input | ADDR_W | Cycle address: low IDX_W bits are the line index, the rest is the tag |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through |
| freeze_req | input | 1 | Requested freeze state |
| init_busy | input | 1 | Cache initialisation in progress |
| lookup_hit | output | 1 | The addressed line is valid and its tag matches |
| line_dirty | output | 1 | Dirty bit of the addressed line |
| tag_we | output | 1 | Tag RAM write enable |
| data_we | output | 1 | Data RAM write enable |
| dirty_we | output | 1 | Dirty bit write enable |
| dirty_wdata | output | 1 | Value written to the dirty bit |
| fill_req | output | 1 | Line fill from main memory requested |
| evict_wb | output | 1 | Victim line is dirty and must be written back |
| freeze_active | output | 1 | Freeze state in force |

## Verification
The checker tests the following on every cycle:
- that frozen read misses never allocate;
- that write misses and read hits stay quiet;
- that write-through never touches the dirty bit;
- that initialisation blocks all enables and holds the freeze state;
- that an eviction write-back only accompanies an allocation.

Some behaviours only show up across a sequence of cycles, so only the bench's scenarios can show them:
- that the array really is unchanged after a long run of frozen misses, seen as earlier addresses still hitting;
- that dirty bits set while frozen are visible later;
- that a freeze request made during initialisation lands on the first cycle after it.

The bench's behavioural model is compared with every output on every clock, during directed sequences and a long random mix.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RD_HIT,
    ACC_RD_MISS,
    ACC_WR_HIT,
    ACC_WR_MISS
  } acc_e;

  typedef struct packed {
    logic tag_we;
    logic data_we;
    logic dirty_we;
    logic dirty_set;
    logic fill;
  } upd_t;

endpackage

// File: rtl/cdir_freeze_gate.sv
module cdir_freeze_gate (
  input  logic clk,
  input  logic srst_n,
  input  logic freeze_req,
  input  logic init_busy,
  output logic freeze_active
);

  logic frz_en;
  logic frz_nxt;

  // A request made during initialisation waits here until init ends
  always_comb begin
    frz_en  = !init_busy;
    frz_nxt = freeze_active;
    if (frz_en) begin
      frz_nxt = freeze_req;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      freeze_active <= 1'b0;
    end else if (frz_en) begin
      freeze_active <= frz_nxt;
    end
  end

endmodule

// File: rtl/cdir_line_store.sv
module cdir_line_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             init_clr,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             alloc_we,
  input  logic             dirty_we,
  input  logic             dirty_wdata,
  output logic             hit,
  output logic             line_valid,
  output logic             line_dirty
);

  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_vec;
  logic [LINES-1:0] dirty_vec;
  logic [TAG_W-1:0] tag_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             sel;
    logic             v_q, v_nxt, v_en;
    logic             d_q, d_nxt, d_en;
    logic [TAG_W-1:0] t_q;
    logic             t_en;

    assign sel = (rd_idx == IDX_W'(g));

    always_comb begin
      v_en  = init_clr || (sel && alloc_we);
      v_nxt = !init_clr;
      d_en  = init_clr || (sel && dirty_we);
      d_nxt = !init_clr && dirty_wdata;
      t_en  = !init_clr && sel && alloc_we;
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else begin
        if (v_en) v_q <= v_nxt;
        if (d_en) d_q <= d_nxt;
      end
    end

    always_ff @(posedge clk) begin
      if (t_en) t_q <= rd_tag;
    end

    assign valid_vec[g] = v_q;
    assign dirty_vec[g] = d_q;
    assign tag_arr[g]   = t_q;
  end

  assign line_valid = valid_vec[rd_idx];
  assign line_dirty = dirty_vec[rd_idx];
  assign hit        = line_valid && (tag_arr[rd_idx] == rd_tag);

endmodule

// File: rtl/cdir_update_decide.sv
module cdir_update_decide
  import cdir_pkg::*;
(
  input  logic cyc_valid,
  input  logic cyc_write,
  input  logic hit,
  input  logic wb_mode,
  input  logic frozen,
  input  logic init_busy,
  input  logic victim_valid,
  input  logic victim_dirty,
  output upd_t upd,
  output logic evict_wb
);

  acc_e kind;

  always_comb begin
    kind = ACC_NONE;
    if (cyc_valid && !init_busy) begin
      case ({cyc_write, hit})
        2'b00:   kind = ACC_RD_MISS;
        2'b01:   kind = ACC_RD_HIT;
        2'b10:   kind = ACC_WR_MISS;
        default: kind = ACC_WR_HIT;
      endcase
    end
  end

  always_comb begin
    upd      = '0;
    evict_wb = 1'b0;
    case (kind)
      ACC_RD_MISS: begin
        if (!frozen) begin
          upd.tag_we   = 1'b1;
          upd.data_we  = 1'b1;
          upd.fill     = 1'b1;
          upd.dirty_we = 1'b1;   // new line starts clean
          evict_wb     = victim_valid && victim_dirty;
        end
      end
      ACC_WR_HIT: begin
        upd.data_we = 1'b1;
        if (wb_mode) begin
          upd.dirty_we  = 1'b1;
          upd.dirty_set = 1'b1;
        end
      end
      default: upd = '0;
    endcase
  end

endmodule

// File: rtl/cdir_freeze_ctrl.sv
module cdir_freeze_ctrl
  import cdir_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic              cyc_write,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              wb_mode,
  input  logic              freeze_req,
  input  logic              init_busy,
  output logic              lookup_hit,
  output logic              line_dirty,
  output logic              tag_we,
  output logic              data_we,
  output logic              dirty_we,
  output logic              dirty_wdata,
  output logic              fill_req,
  output logic              evict_wb,
  output logic              freeze_active
);

  localparam int TAG_W = ADDR_W - IDX_W;

  logic [1:0] rs_q;
  logic       srst_n;
  logic       line_valid;
  upd_t       upd;

  // Reset asserts at once and is released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  cdir_freeze_gate u_gate (
    .clk           (clk),
    .srst_n        (srst_n),
    .freeze_req    (freeze_req),
    .init_busy     (init_busy),
    .freeze_active (freeze_active)
  );

  cdir_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk         (clk),
    .srst_n      (srst_n),
    .init_clr    (init_busy),
    .rd_idx      (cyc_addr[IDX_W-1:0]),
    .rd_tag      (cyc_addr[ADDR_W-1:IDX_W]),
    .alloc_we    (upd.tag_we),
    .dirty_we    (upd.dirty_we),
    .dirty_wdata (upd.dirty_set),
    .hit         (lookup_hit),
    .line_valid  (line_valid),
    .line_dirty  (line_dirty)
  );

  cdir_update_decide u_decide (
    .cyc_valid    (cyc_valid),
    .cyc_write    (cyc_write),
    .hit          (lookup_hit),
    .wb_mode      (wb_mode),
    .frozen       (freeze_active),
    .init_busy    (init_busy),
    .victim_valid (line_valid),
    .victim_dirty (line_dirty),
    .upd          (upd),
    .evict_wb     (evict_wb)
  );

  assign tag_we      = upd.tag_we;
  assign data_we     = upd.data_we;
  assign dirty_we    = upd.dirty_we;
  assign dirty_wdata = upd.dirty_set;
  assign fill_req    = upd.fill;

endmodule

// File: rtl/cdir_freeze_ctrl_chk.sv
module cdir_freeze_ctrl_chk (
  input logic clk,
  input logic srst_n,
  input logic cyc_valid,
  input logic cyc_write,
  input logic wb_mode,
  input logic freeze_req,
  input logic init_busy,
  input logic lookup_hit,
  input logic tag_we,
  input logic data_we,
  input logic dirty_we,
  input logic dirty_wdata,
  input logic fill_req,
  input logic evict_wb,
  input logic freeze_active
);

  logic any_en;
  assign any_en = tag_we || data_we || dirty_we || fill_req;

  assert_frozen_miss_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (freeze_active && cyc_valid && !cyc_write && !lookup_hit) |-> !any_en);

  assert_wb_write_hit_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc_valid && cyc_write && lookup_hit && wb_mode && !init_busy)
      |-> (data_we && dirty_we && dirty_wdata));

  assert_wt_no_dirty_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc_write && !wb_mode) |-> !dirty_we);

  assert_write_miss_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc_write && !lookup_hit) |-> !any_en);

  assert_read_hit_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (!cyc_write && lookup_hit) |-> !any_en);

  assert_freeze_follow_R7: assert property (@(posedge clk) disable iff (!srst_n)
    !init_busy |=> (freeze_active == $past(freeze_req)));

  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!srst_n)
    init_busy |=> $stable(freeze_active));

  assert_init_quiet_R9: assert property (@(posedge clk) disable iff (!srst_n)
    init_busy |-> (!any_en && !evict_wb));

  assert_evict_alloc_R10: assert property (@(posedge clk) disable iff (!srst_n)
    evict_wb |-> (fill_req && tag_we && !freeze_active));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!srst_n)
    !cyc_valid |-> (!any_en && !evict_wb));

endmodule

bind cdir_freeze_ctrl cdir_freeze_ctrl_chk u_chk (.*);

// File: tb/cdir_freeze_ctrl_bench.sv
module cdir_freeze_ctrl_bench;

  localparam int ADDR_W = 12;
  localparam int IDX_W  = 4;
  localparam int LINES  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cyc_valid, cyc_write, wb_mode, freeze_req, init_busy;
  logic [ADDR_W-1:0] cyc_addr;
  logic lookup_hit, line_dirty, tag_we, data_we, dirty_we, dirty_wdata;
  logic fill_req, evict_wb, freeze_active;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  bit m_valid [LINES];
  bit m_dirty [LINES];
  int m_tag   [LINES];
  bit m_frz;

  always #10 clk = ~clk;   // 50 MHz

  cdir_freeze_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cdir_freeze_ctrl (.*);

  task automatic chk(input string rq, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", rq, nm, act, exp);
    end
  endtask

  function automatic string rtag(bit v, bit w, bit ib, bit h, bit f, bit wb);
    if (!v)  return "R12";
    if (ib)  return "R9";
    if (!w)  return h ? "R6" : (f ? "R2" : "R1");
    if (!h)  return "R5";
    return wb ? "R3" : "R4";
  endfunction

  // one clock cycle: drive, compare mid-phase, advance model at the edge
  task automatic cyc(input bit v, input bit w, input int a, input bit wb,
                     input bit fz, input bit ib, input string rq);
    int  idx = a % LINES;
    int  tg  = a / LINES;
    bit  e_hit, act, alloc, whit, e_ev;
    cyc_valid = v; cyc_write = w; cyc_addr = ADDR_W'(a);
    wb_mode = wb; freeze_req = fz; init_busy = ib;
    #2;
    e_hit = m_valid[idx] && (m_tag[idx] == tg);
    act   = v && !ib;
    alloc = act && !w && !e_hit && !m_frz;
    whit  = act && w && e_hit;
    e_ev  = alloc && m_valid[idx] && m_dirty[idx];
    chk(rq, "lookup_hit", int'(lookup_hit), int'(e_hit));
    chk(rq, "line_dirty", int'(line_dirty), int'(m_dirty[idx]));
    chk(rq, "tag_we", int'(tag_we), int'(alloc));
    chk(rq, "data_we", int'(data_we), int'(alloc || whit));
    chk(rq, "dirty_we", int'(dirty_we), int'(alloc || (whit && wb)));
    chk(rq, "dirty_wdata", int'(dirty_wdata), int'(whit && wb));
    chk(rq, "fill_req", int'(fill_req), int'(alloc));
    chk(rq, "evict_wb", int'(evict_wb), int'(e_ev));
    chk(rq, "freeze_active", int'(freeze_active), int'(m_frz));
    @(posedge clk);
    if (ib) begin
      for (int i = 0; i < LINES; i++) begin
        m_valid[i] = 1'b0;
        m_dirty[i] = 1'b0;
      end
    end else begin
      if (alloc) begin
        m_valid[idx] = 1'b1;
        m_tag[idx]   = tg;
        m_dirty[idx] = 1'b0;
      end
      if (whit && wb) m_dirty[idx] = 1'b1;
      m_frz = fz;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_valid[i] = 1'b0;
      m_dirty[i] = 1'b0;
      m_tag[i]   = 0;
    end
    m_frz = 1'b0;
    rst_n = 1'b0;
    cyc_valid = 1'b0; cyc_write = 1'b0; cyc_addr = '0;
    wb_mode = 1'b1; freeze_req = 1'b0; init_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state, idle through reset release
    repeat (3) cyc(0, 0, 0, 1, 0, 0, "R11");
    cyc(1, 0, 'h123, 1, 0, 0, "R11");          // first lookup misses

    // R1: allocate eight lines in write-back mode
    for (int i = 0; i < 8; i++) cyc(1, 0, 'h100 + i, 1, 0, 0, "R1");
    // R6: read hits stay quiet
    for (int i = 0; i < 8; i++) cyc(1, 0, 'h100 + i, 1, 0, 0, "R6");
    // R3: write hits mark lines dirty
    for (int i = 0; i < 4; i++) cyc(1, 1, 'h100 + i, 1, 0, 0, "R3");
    cyc(1, 0, 'h101, 1, 0, 0, "R3");           // dirty visible
    // R10: replacing a dirty line requests write-back
    cyc(1, 0, 'h200, 1, 0, 0, "R10");

    // R7: freeze engages one edge later
    cyc(0, 0, 0, 1, 1, 0, "R7");
    // R2: many frozen read misses leave the array alone
    for (int i = 0; i < 40; i++) cyc(1, 0, 'h300 + i * 3, 1, 1, 0, "R2");
    for (int i = 1; i < 8; i++) cyc(1, 0, 'h100 + i, 1, 1, 0, "R2");
    cyc(1, 0, 'h200, 1, 1, 0, "R2");
    // R3: frozen write hit still sets dirty
    cyc(1, 1, 'h105, 1, 1, 0, "R3");
    cyc(1, 0, 'h105, 1, 1, 0, "R3");
    // R5: write miss, frozen and not
    cyc(1, 1, 'h555, 1, 1, 0, "R5");
    cyc(1, 0, 'h105, 1, 1, 0, "R6");
    // R10: frozen miss on a dirty victim never evicts
    cyc(1, 0, 'h301, 1, 1, 0, "R10");
    cyc(0, 0, 0, 1, 0, 0, "R7");               // unfreeze
    cyc(1, 1, 'h556, 1, 0, 0, "R5");
    cyc(1, 0, 'h556, 1, 0, 0, "R5");           // write miss did not allocate

    // R4: write-through write hit leaves dirty bit alone
    cyc(1, 1, 'h104, 0, 0, 0, "R4");
    cyc(1, 0, 'h104, 0, 0, 0, "R4");
    cyc(1, 1, 'h101, 0, 0, 0, "R4");           // already dirty stays dirty
    cyc(1, 0, 'h101, 0, 0, 0, "R4");

    // R12: idle cycle with busy-looking inputs
    cyc(0, 1, 'h101, 1, 0, 0, "R12");
    cyc(0, 0, 'h999, 1, 0, 0, "R12");

    // R8 / R9: initialisation with freeze requests toggling
    cyc(1, 0, 'h105, 1, 1, 1, "R9");
    cyc(1, 1, 'h101, 1, 0, 1, "R8");
    cyc(1, 0, 'h777, 1, 1, 1, "R8");
    cyc(1, 0, 'h105, 1, 1, 0, "R8");           // first cycle after init
    cyc(1, 0, 'h101, 1, 1, 0, "R9");           // lines cleared, frozen: miss
    cyc(0, 0, 0, 1, 0, 0, "R7");

    // mixed random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      bit v  = ($urandom_range(0, 9) != 0);
      bit w  = $urandom_range(0, 2) == 0;
      int a  = ($urandom_range(0, 3) * LINES) + $urandom_range(0, LINES - 1);
      bit wb = $urandom_range(0, 3) != 0;
      bit fz = $urandom_range(0, 7) == 0 ? !m_frz : m_frz;
      bit ib = $urandom_range(0, 49) == 0;
      bit h  = m_valid[a % LINES] && (m_tag[a % LINES] == a / LINES);
      cyc(v, w, a, wb, fz, ib, rtag(v, w, ib, h, m_frz, wb));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule